// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control state machine of a 16-bit multi-cycle processor. Its instruction set has 16 operations, selected by a 4-bit opcode. The block reads the opcode field from the instruction register and the zero flag from the ALU. Each clock it steps one state through fetch, decode, execute, memory access and write-back, and drives every control line of the datapath from that state. The datapath itself sits outside the block: the program counter, instruction and data registers, register file, ALU and memory.

Each instruction takes its first cycle for fetch. That cycle reads memory at the PC, loads the instruction register and writes PC+1 back. The second cycle decodes the instruction and reads the registers. In the same cycle the ALU forms the branch target, PC+1 plus the sign-extended 4-bit offset. After decode, each instruction class follows its own short path and then returns to fetch:

| Class | Total cycles |
|-------|--------------|
| Conditional branches | 3 |
| Register jump | 3 |
| Jump-and-link | 3 |
| Stores | 4 |
| ALU and shift operations | 4 |
| Loads | 5 |

Instruction fields are fixed. The opcode is in bits 15:12. The J format holds its 12-bit target in 11:0. The other formats carry the 4-bit immediate, destination or shift amount in 11:8, rt in 7:4 and rs in 3:0.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high, pc_write, mem_rd, mem_wr, ir_wr and rf_wr are all 0. The first cycle after `rst` falls is a fetch cycle.
- R2: A fetch cycle drives:
  - mem_rd=1, ir_wr=1 and pc_write=1.
  - addr_sel=0, the PC address.
  - alu_a_sel=0, the PC.
  - alu_b_sel=1, the constant one.
  - alu_op=0, add.
  - pc_src=0, the ALU result.
- R3: The cycle after fetch is decode. It drives alu_b_sel=2, the sign-extended immediate, with alu_a_sel=0 and alu_op=0 (add), and all enables at 0.
- R4: For opcodes 0000 add, 0001 and, 0010 or, 0011 slt and 1100 sub:
  - Cycle 3 drives alu_a_sel=1 (register A) and alu_b_sel=0 (register B).
  - In cycle 3, alu_op is 0, 1, 2, 3 or 4 respectively.
  - Cycle 4 drives rf_wr=1 with reg_dst=1 (the rd field) and mem_to_reg=0 (the ALU output).
- R5: For opcode 1101 (shift):
  - Cycle 3 drives alu_a_sel=1, alu_b_sel=3 (the zero-extended shift amount) and alu_op=5 (shift left).
  - Cycle 4 drives rf_wr=1 with reg_dst=0 (the rt field) and mem_to_reg=0.
- R6: For opcodes 1000 to 1011 (addi, andi, ori, slti):
  - Cycle 3 drives alu_a_sel=1 and alu_b_sel=2.
  - In cycle 3, alu_op is 0, 1, 2 or 3 respectively.
  - Cycle 4 drives rf_wr=1 with reg_dst=0 and mem_to_reg=0.
- R7: Load (0100) takes 5 cycles:
  - Cycle 3 drives alu_a_sel=1, alu_b_sel=2 and alu_op=0.
  - Cycle 4 drives mem_rd=1 with addr_sel=1, the ALU output register.
  - Cycle 5 drives rf_wr=1 with reg_dst=0 and mem_to_reg=1, the memory data register.
- R8: Store (0101) takes 4 cycles. Cycle 3 is the same as for a load. Cycle 4 drives mem_wr=1 with addr_sel=1.
- R9: beq (0110) and bne (0111) take 3 cycles. Cycle 3 drives:
  - alu_a_sel=1, alu_b_sel=0 and alu_op=4 (subtract).
  - pc_src=1, the latched branch target.
  - pc_write=1 only when `zero` is 1 for beq, or 0 for bne, in that cycle.
- R10: jr (1110) takes 3 cycles. Cycle 3 drives pc_write=1 with pc_src=3, register A.
- R11: jal (1111) takes 3 cycles. Cycle 3 drives all of the following:
  - pc_write=1 with pc_src=2, the jump address {PC[15:12], target}.
  - rf_wr=1 with reg_dst=2, register 15.
  - mem_to_reg=2, the already incremented PC.
- R12: Any output not named for a cycle above is 0 in that cycle. mem_rd and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Instruction register bits 15:12 |
| zero | input | 1 | ALU zero flag |
| pc_write | output | 1 | PC load enable, with the branch condition already applied |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 0 register B, 1 one, 2 sign-extended immediate, 3 shift amount |
| alu_op | output | 3 | 0 add, 1 and, 2 or, 3 slt, 4 sub, 5 shift left |
| reg_dst | output | 2 | Write register: 0 rt, 1 rd, 2 register 15 |
| mem_to_reg | output | 2 | Write data: 0 ALU output, 1 memory data, 2 PC |
| pc_src | output | 2 | PC source: 0 ALU result, 1 branch target, 2 jump address, 3 register A |

## Verification
The block has no parameters, so the bench builds its only configuration, with encodings fixed by the package. That configuration reaches every state, every opcode and both values of the zero flag. The checks cover:
- Branch decisions taken both ways, for beq and for bne.
- Back-to-back instructions of every length, which show that each path returns to fetch in the right cycle.
- A reset raised in the middle of a load, which shows the enables going quiet at once.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ALU_R, ST_ALU_SH, ST_ALU_I,
        ST_ADDR, ST_MRD, ST_MWR, ST_LDWB, ST_WB_RD, ST_WB_RT,
        ST_BRANCH, ST_JR, ST_JAL
    } state_e;

    localparam logic [OPC_W-1:0] OP_ADD  = 4'b0000;
    localparam logic [OPC_W-1:0] OP_AND  = 4'b0001;
    localparam logic [OPC_W-1:0] OP_OR   = 4'b0010;
    localparam logic [OPC_W-1:0] OP_SLT  = 4'b0011;
    localparam logic [OPC_W-1:0] OP_LW   = 4'b0100;
    localparam logic [OPC_W-1:0] OP_SW   = 4'b0101;
    localparam logic [OPC_W-1:0] OP_BEQ  = 4'b0110;
    localparam logic [OPC_W-1:0] OP_BNE  = 4'b0111;
    localparam logic [OPC_W-1:0] OP_ADDI = 4'b1000;
    localparam logic [OPC_W-1:0] OP_ANDI = 4'b1001;
    localparam logic [OPC_W-1:0] OP_ORI  = 4'b1010;
    localparam logic [OPC_W-1:0] OP_SLTI = 4'b1011;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'b1100;
    localparam logic [OPC_W-1:0] OP_SHF  = 4'b1101;
    localparam logic [OPC_W-1:0] OP_JR   = 4'b1110;
    localparam logic [OPC_W-1:0] OP_JAL  = 4'b1111;

    localparam logic [ALUOP_W-1:0] AOP_ADD = 3'd0;
    localparam logic [ALUOP_W-1:0] AOP_AND = 3'd1;
    localparam logic [ALUOP_W-1:0] AOP_OR  = 3'd2;
    localparam logic [ALUOP_W-1:0] AOP_SLT = 3'd3;
    localparam logic [ALUOP_W-1:0] AOP_SUB = 3'd4;
    localparam logic [ALUOP_W-1:0] AOP_SHL = 3'd5;

    localparam logic [SEL_W-1:0] BSEL_REG = 2'd0;
    localparam logic [SEL_W-1:0] BSEL_ONE = 2'd1;
    localparam logic [SEL_W-1:0] BSEL_IMM = 2'd2;
    localparam logic [SEL_W-1:0] BSEL_SHA = 2'd3;

    localparam logic [SEL_W-1:0] DST_RT  = 2'd0;
    localparam logic [SEL_W-1:0] DST_RD  = 2'd1;
    localparam logic [SEL_W-1:0] DST_R15 = 2'd2;

    localparam logic [SEL_W-1:0] WD_ALU = 2'd0;
    localparam logic [SEL_W-1:0] WD_MDR = 2'd1;
    localparam logic [SEL_W-1:0] WD_PC  = 2'd2;

    localparam logic [SEL_W-1:0] PCS_ALU = 2'd0;
    localparam logic [SEL_W-1:0] PCS_TGT = 2'd1;
    localparam logic [SEL_W-1:0] PCS_JMP = 2'd2;
    localparam logic [SEL_W-1:0] PCS_REG = 2'd3;

    typedef struct packed {
        logic               pc_write;
        logic               mem_rd;
        logic               mem_wr;
        logic               ir_wr;
        logic               rf_wr;
        logic               addr_sel;
        logic               alu_a_sel;
        logic [SEL_W-1:0]   alu_b_sel;
        logic [ALUOP_W-1:0] alu_op;
        logic [SEL_W-1:0]   reg_dst;
        logic [SEL_W-1:0]   mem_to_reg;
        logic [SEL_W-1:0]   pc_src;
    } ctrl_t;

endpackage

// File: rtl/mcf_aluop.sv
module mcf_aluop
    import mcf_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    output logic [ALUOP_W-1:0] func
);
    always_comb begin
        unique case (opcode)
            OP_ADD, OP_ADDI: func = AOP_ADD;
            OP_AND, OP_ANDI: func = AOP_AND;
            OP_OR,  OP_ORI:  func = AOP_OR;
            OP_SLT, OP_SLTI: func = AOP_SLT;
            OP_SUB:          func = AOP_SUB;
            OP_SHF:          func = AOP_SHL;
            default:         func = AOP_ADD;
        endcase
    end
endmodule

// File: rtl/mcf_seq.sv
module mcf_seq
    import mcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output state_e           state_q
);
    typedef struct packed {
        state_e state;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_FETCH:  s_d.state = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode)
                    OP_ADD, OP_AND, OP_OR, OP_SLT, OP_SUB:
                        s_d.state = ST_ALU_R;
                    OP_SHF:
                        s_d.state = ST_ALU_SH;
                    OP_ADDI, OP_ANDI, OP_ORI, OP_SLTI:
                        s_d.state = ST_ALU_I;
                    OP_LW, OP_SW:
                        s_d.state = ST_ADDR;
                    OP_BEQ, OP_BNE:
                        s_d.state = ST_BRANCH;
                    OP_JR:
                        s_d.state = ST_JR;
                    default:
                        s_d.state = ST_JAL;
                endcase
            end
            ST_ADDR:   s_d.state = (opcode == OP_LW) ? ST_MRD : ST_MWR;
            ST_MRD:    s_d.state = ST_LDWB;
            ST_ALU_R:  s_d.state = ST_WB_RD;
            ST_ALU_SH,
            ST_ALU_I:  s_d.state = ST_WB_RT;
            default:   s_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{state: ST_FETCH};
        else     s_q <= s_d;
    end

    assign state_q = s_q.state;

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH |=> state_q == ST_DECODE);               // R3
    AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MRD |=> state_q == ST_LDWB);                   // R7
    AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_BRANCH |=> state_q == ST_FETCH);               // R9
    AST_RESET_FETCH: assert property (@(posedge clk)
        rst |=> state_q == ST_FETCH);                                // R1
endmodule

// File: rtl/mcf_outdec.sv
module mcf_outdec
    import mcf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  state_e             state,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               zero,
    input  logic [ALUOP_W-1:0] func,
    output ctrl_t              ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.pc_write  = 1'b1;
                ctrl.alu_b_sel = BSEL_ONE;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE: ctrl.alu_b_sel = BSEL_IMM;
            ST_ALU_R: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REG;
                ctrl.alu_op    = func;
            end
            ST_ALU_SH: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_SHA;
                ctrl.alu_op    = AOP_SHL;
            end
            ST_ALU_I: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_op    = func;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_MRD: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_MWR: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl.rf_wr      = 1'b1;
                ctrl.reg_dst    = DST_RT;
                ctrl.mem_to_reg = WD_MDR;
            end
            ST_WB_RD: begin
                ctrl.rf_wr   = 1'b1;
                ctrl.reg_dst = DST_RD;
            end
            ST_WB_RT: begin
                ctrl.rf_wr   = 1'b1;
                ctrl.reg_dst = DST_RT;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REG;
                ctrl.alu_op    = AOP_SUB;
                ctrl.pc_src    = PCS_TGT;
                ctrl.pc_write  = zero ^ opcode[0];
            end
            ST_JR: begin
                ctrl.pc_write = 1'b1;
                ctrl.pc_src   = PCS_REG;
            end
            ST_JAL: begin
                ctrl.pc_write   = 1'b1;
                ctrl.pc_src     = PCS_JMP;
                ctrl.rf_wr      = 1'b1;
                ctrl.reg_dst    = DST_R15;
                ctrl.mem_to_reg = WD_PC;
            end
            default: ctrl = '0;
        endcase
        if (rst) begin
            ctrl.pc_write = 1'b0;
            ctrl.mem_rd   = 1'b0;
            ctrl.mem_wr   = 1'b0;
            ctrl.ir_wr    = 1'b0;
            ctrl.rf_wr    = 1'b0;
        end
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mem_rd && ctrl.mem_wr));                              // R12
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode,
    input  logic                 zero,
    output logic                 pc_write,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 ir_wr,
    output logic                 rf_wr,
    output logic                 addr_sel,
    output logic                 alu_a_sel,
    output logic [SEL_W-1:0]     alu_b_sel,
    output logic [ALUOP_W-1:0]   alu_op,
    output logic [SEL_W-1:0]     reg_dst,
    output logic [SEL_W-1:0]     mem_to_reg,
    output logic [SEL_W-1:0]     pc_src
);
    state_e             state;
    logic [ALUOP_W-1:0] func;
    ctrl_t              ctrl;

    mcf_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .state_q (state)
    );

    mcf_aluop u_aluop (
        .opcode (opcode),
        .func   (func)
    );

    mcf_outdec u_outdec (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .opcode (opcode),
        .zero   (zero),
        .func   (func),
        .ctrl   (ctrl)
    );

    assign pc_write   = ctrl.pc_write;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign ir_wr      = ctrl.ir_wr;
    assign rf_wr      = ctrl.rf_wr;
    assign addr_sel   = ctrl.addr_sel;
    assign alu_a_sel  = ctrl.alu_a_sel;
    assign alu_b_sel  = ctrl.alu_b_sel;
    assign alu_op     = ctrl.alu_op;
    assign reg_dst    = ctrl.reg_dst;
    assign mem_to_reg = ctrl.mem_to_reg;
    assign pc_src     = ctrl.pc_src;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !(pc_write || mem_rd || mem_wr || ir_wr || rf_wr));   // R1
    AST_FETCH_ONCE: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> !ir_wr);                                           // R2
    AST_BRANCH_COND: assert property (@(posedge clk) disable iff (rst)
        (pc_write && pc_src == PCS_TGT) |-> (zero != opcode[0]));    // R9
endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'd0;
    logic       zero = 1'b0;
    logic       pc_write, mem_rd, mem_wr, ir_wr, rf_wr, addr_sel, alu_a_sel;
    logic [1:0] alu_b_sel, reg_dst, mem_to_reg, pc_src;
    logic [2:0] alu_op;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
        .pc_write(pc_write), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .rf_wr(rf_wr), .addr_sel(addr_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .reg_dst(reg_dst),
        .mem_to_reg(mem_to_reg), .pc_src(pc_src)
    );

    // {pc_write, mem_rd, mem_wr, ir_wr, rf_wr, addr_sel, alu_a_sel,
    //  alu_b_sel[2], alu_op[3], reg_dst[2], mem_to_reg[2], pc_src[2]}
    function automatic logic [17:0] mk(bit pw, bit mr, bit mw, bit iw, bit rw,
                                       bit as, bit a, logic [1:0] b, logic [2:0] op,
                                       logic [1:0] rd, logic [1:0] m2r, logic [1:0] ps);
        return {pw, mr, mw, iw, rw, as, a, b, op, rd, m2r, ps};
    endfunction

    function automatic int instr_len(logic [3:0] op);
        if (op == 4'b0100) return 5;
        if (op inside {4'b0110, 4'b0111, 4'b1110, 4'b1111}) return 3;
        return 4;
    endfunction

    function automatic logic [2:0] exp_func(logic [3:0] op);
        if (op == 4'b1100) return 3'd4;
        return {1'b0, op[1:0]};
    endfunction

    function automatic string req_of(logic [3:0] op, int cyc);
        if (cyc == 1) return "R2";
        if (cyc == 2) return "R3";
        case (op)
            4'b1101: return "R5";
            4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R6";
            4'b0100: return "R7";
            4'b0101: return "R8";
            4'b0110, 4'b0111: return "R9";
            4'b1110: return "R10";
            4'b1111: return "R11";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [17:0] exp_ctrl(logic [3:0] op, int cyc, bit z);
        if (cyc == 1) return mk(1,1,0,1,0,0,0,2'd1,3'd0,2'd0,2'd0,2'd0);   // R2
        if (cyc == 2) return mk(0,0,0,0,0,0,0,2'd2,3'd0,2'd0,2'd0,2'd0);   // R3
        case (op)
            4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1100:                  // R4
                return (cyc == 3) ? mk(0,0,0,0,0,0,1,2'd0,exp_func(op),2'd0,2'd0,2'd0)
                                  : mk(0,0,0,0,1,0,0,2'd0,3'd0,2'd1,2'd0,2'd0);
            4'b1101:                                                      // R5
                return (cyc == 3) ? mk(0,0,0,0,0,0,1,2'd3,3'd5,2'd0,2'd0,2'd0)
                                  : mk(0,0,0,0,1,0,0,2'd0,3'd0,2'd0,2'd0,2'd0);
            4'b1000, 4'b1001, 4'b1010, 4'b1011:                           // R6
                return (cyc == 3) ? mk(0,0,0,0,0,0,1,2'd2,exp_func(op),2'd0,2'd0,2'd0)
                                  : mk(0,0,0,0,1,0,0,2'd0,3'd0,2'd0,2'd0,2'd0);
            4'b0100: begin                                                // R7
                if (cyc == 3) return mk(0,0,0,0,0,0,1,2'd2,3'd0,2'd0,2'd0,2'd0);
                if (cyc == 4) return mk(0,1,0,0,0,1,0,2'd0,3'd0,2'd0,2'd0,2'd0);
                return mk(0,0,0,0,1,0,0,2'd0,3'd0,2'd0,2'd1,2'd0);
            end
            4'b0101:                                                      // R8
                return (cyc == 3) ? mk(0,0,0,0,0,0,1,2'd2,3'd0,2'd0,2'd0,2'd0)
                                  : mk(0,0,1,0,0,1,0,2'd0,3'd0,2'd0,2'd0,2'd0);
            4'b0110, 4'b0111:                                             // R9
                return mk(bit'(z ^ op[0]),0,0,0,0,0,1,2'd0,3'd4,2'd0,2'd0,2'd1);
            4'b1110: return mk(1,0,0,0,0,0,0,2'd0,3'd0,2'd0,2'd0,2'd3); // R10
            default: return mk(1,0,0,0,1,0,0,2'd0,3'd0,2'd2,2'd2,2'd2); // R11
        endcase
    endfunction

    function automatic logic [17:0] actual();
        return {pc_write, mem_rd, mem_wr, ir_wr, rf_wr, addr_sel, alu_a_sel,
                alu_b_sel, alu_op, reg_dst, mem_to_reg, pc_src};
    endfunction

    // Entered at a negedge with the design in fetch; leaves at the negedge of the next fetch.
    task automatic run_instr(logic [3:0] op, int zmode);
        int len = instr_len(op);
        for (int c = 1; c <= len; c++) begin
            opcode = op;
            zero = (zmode < 0) ? 1'($urandom) : 1'(zmode);
            #1;
            n_chk++;
            if (actual() !== exp_ctrl(op, c, zero)) begin
                n_fail++;
                $display("FAIL %s op=%b cyc=%0d zero=%b actual=%h expected=%h",
                         req_of(op, c), op, c, zero, actual(), exp_ctrl(op, c, zero));
            end
            // R12: read and write never overlap
            n_chk++;
            if (mem_rd && mem_wr) begin
                n_fail++;
                $display("FAIL R12 op=%b cyc=%0d actual rd/wr=%b%b expected not both",
                         op, c, mem_rd, mem_wr);
            end
            @(negedge clk);
        end
    endtask

    task automatic hold_reset(int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            opcode = 4'($urandom);
            zero   = 1'($urandom);
            #1;
            n_chk++;
            if ({pc_write, mem_rd, mem_wr, ir_wr, rf_wr} !== 5'b0) begin
                n_fail++;
                $display("FAIL R1 enables during reset actual=%b expected=00000",
                         {pc_write, mem_rd, mem_wr, ir_wr, rf_wr});
            end
            @(negedge clk);
        end
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h0000_C0DE));
        @(negedge clk);
        hold_reset(3);                                   // R1

        // Directed: every opcode, both zero values
        for (int z = 0; z < 2; z++)
            for (int o = 0; o < 16; o++)
                run_instr(4'(o), z);

        // Branch pair taken/not taken, back to back (R9)
        run_instr(4'b0110, 1);
        run_instr(4'b0110, 0);
        run_instr(4'b0111, 0);
        run_instr(4'b0111, 1);

        // Reset raised in the middle of a load (R1, R7)
        opcode = 4'b0100;
        zero = 1'b0;
        repeat (3) @(negedge clk);
        hold_reset(2);
        run_instr(4'b0100, -1);

        // Constrained random stream
        for (int i = 0; i < 400; i++)
            run_instr(4'($urandom), -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule